// File: doc/BRIEF.md
# SCSI Glue Control and Status Registers

This block holds two byte-wide registers that sit beside a SCSI protocol chip. A one-bit byte offset selects the register. Register 0 is the command/status byte. A write to it can do three things: pulse a reset into the SCSI chip, scrub selected status fields from the stored value, and set or clear a DMA-request bit that the block drives into the system interrupt-status word. Register 1 is a plain storage byte.

Every access carries a width code that gives the number of bytes. Only one-byte accesses do anything. Any other width is dropped: the write changes nothing and the read returns zero. Reads come straight from the stored bytes in the same cycle as the request. Write side effects appear on the clock edge that accepts the write.

Register 0 bit map, from the least significant bit: bit 0 is the enable, bit 1 the chip reset, bit 2 the DMA direction, bit 3 the FIFO flush, bit 4 the CPU-DMA request, bit 5 the interrupt mask. Bit 6 is spare and bit 7 is a status flag.

Top module: `scsi_glue_csr`

## Requirements
- R1: After a synchronous reset, register 0 reads 0x00 and register 1 reads the parameter `REG1_INIT` (default 0x3C). The reset pulse is low and the interrupt contribution `irq_status` is all zeros.
- R2: A one-byte write to offset 1 stores the byte. A later one-byte read of offset 1 returns it.
- R3: A one-byte write to offset 0 with bit 1 (chip reset, mask 0x02) clear stores the byte unchanged. A read of offset 0 returns it.
- R4: A one-byte write to offset 0 with bit 1 set stores the written byte with bits 0, 5 and 7 forced to zero (mask 0xA1 cleared).
- R5: A one-byte write to offset 0 with bit 1 set raises `scsi_chip_rst` for exactly the one clock that follows the accepting edge. The signal is never high otherwise.
- R6: Every accepted write to offset 0 copies its bit 4 (CPU-DMA, mask 0x10) into bit `DMA_IRQ_BIT` (default 26, 0x04000000) of `irq_status`. No other bit of `irq_status` is ever set. The bit holds its value until the next accepted write to offset 0.
- R7: An access whose width code is not 1 is ignored. A write changes neither register, the reset pulse, nor `irq_status`. A read returns 0x00.
- R8: A write to offset 0 with the reset bit set leaves register 1 unchanged. A write to offset 1 affects neither `irq_status` nor `scsi_chip_rst`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 1 | Register select: 0 = command/status, 1 = storage byte |
| acc_bytes | input | 3 | Access width in bytes; only 1 is legal |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, same cycle; zero when not a legal read |
| scsi_chip_rst | output | 1 | One-clock reset pulse to the SCSI chip |
| irq_status | output | 32 | Contribution to the system interrupt-status word |

## Verification
Chip reset and the CPU-DMA request can fall in the same cycle, because one register 0 write can carry both bits. The bench writes 0xB3, which sets reset, CPU-DMA, mask, bit 7 and enable together. In the following cycle it expects the pulse high, the interrupt bit set, and a stored value of 0x12 with only the scrubbed fields removed. A second pair provokes back-to-back reset writes. There the pulse must stay high across both cycles and fall one clock after the last write.

// File: rtl/scsi_glue_pkg.sv
// Package: shared constants for the SCSI glue register block.
// Assumes byte-wide registers; bit positions below are fixed by the
// register contract and are decoded by the surrounding system.
package scsi_glue_pkg;
    localparam int unsigned REG_W      = 8;
    localparam int unsigned BYTES_W    = 3;
    localparam int unsigned IRQ_W      = 32;

    localparam int unsigned BIT_ENABLE = 0;
    localparam int unsigned BIT_RESET  = 1;
    localparam int unsigned BIT_DMADIR = 2;
    localparam int unsigned BIT_FLUSH  = 3;
    localparam int unsigned BIT_CPUDMA = 4;
    localparam int unsigned BIT_IMASK  = 5;
    localparam int unsigned BIT_FLAG7  = 7;

    // Fields scrubbed from the stored byte when a reset is commanded.
    localparam logic [REG_W-1:0] SCRUB_MASK =
        (8'h1 << BIT_IMASK) | (8'h1 << BIT_FLAG7) | (8'h1 << BIT_ENABLE);

    typedef enum logic {
        SEL_CMD  = 1'b0,
        SEL_BYTE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/scsi_glue_decode.sv
// Module: access decoder. Qualifies a bus access as legal (one byte
// wide) and turns it into per-register write strobes plus a read
// enable. Assumes the access fields are stable during acc_valid.
module scsi_glue_decode
    import scsi_glue_pkg::*;
#(
    parameter int unsigned LEGAL_BYTES = 1
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_offset,
    input  logic [BYTES_W-1:0] acc_bytes,
    output logic               wr_cmd,
    output logic               wr_byte,
    output logic               rd_ok
);
    logic legal;

    // Purpose: decide legality and fan out strobes.
    always_comb begin
        legal   = acc_valid && (acc_bytes == BYTES_W'(LEGAL_BYTES));
        wr_cmd  = legal && acc_write && (reg_sel_e'(acc_offset) == SEL_CMD);
        wr_byte = legal && acc_write && (reg_sel_e'(acc_offset) == SEL_BYTE);
        rd_ok   = legal && !acc_write;
    end

    // Guard: at most one register written per cycle (R2, R3).
    always_comb begin
        assert_single_strobe_R3: assert ($onehot0({wr_cmd, wr_byte}));
    end
endmodule

// File: rtl/scsi_glue_cmd_reg.sv
// Module: command/status register (offset 0) with its write side
// effects: a one-clock chip reset pulse, scrubbing of selected fields
// and the CPU-DMA interrupt level. Assumes wr_en is a single-cycle
// qualified strobe from the decoder.
module scsi_glue_cmd_reg
    import scsi_glue_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value,
    output logic             chip_rst,
    output logic             dma_level
);
    logic             rst_cmd;
    logic [REG_W-1:0] next_value;

    // Purpose: form the byte to store from the written data.
    always_comb begin
        rst_cmd    = wdata[BIT_RESET];
        next_value = rst_cmd ? (wdata & ~SCRUB_MASK) : wdata;
    end

    // Purpose: stored byte, reset pulse and DMA interrupt level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value     <= '0;
            chip_rst  <= 1'b0;
            dma_level <= 1'b0;
        end else begin
            chip_rst <= wr_en && rst_cmd;
            if (wr_en) begin
                value     <= next_value;
                dma_level <= wdata[BIT_CPUDMA];
            end
        end
    end

    // The pulse drops after one clock unless a new reset write arrives.
    assert_pulse_one_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst && !(wr_en && wdata[BIT_RESET])) |=> !chip_rst);

    // A reset write leaves the scrubbed fields clear in the stored byte.
    assert_scrub_applied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst |-> ((value & SCRUB_MASK) == '0));

    // The interrupt level changes only on a register 0 write.
    assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dma_level));
endmodule

// File: rtl/scsi_glue_byte_reg.sv
// Module: plain read/write byte (offset 1). Holds a reset value given by
// parameter and changes only on its own write strobe.
module scsi_glue_byte_reg
    import scsi_glue_pkg::*;
#(
    parameter logic [REG_W-1:0] INIT = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value
);
    // Purpose: store the written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= INIT;
        end else if (wr_en) begin
            value <= wdata;
        end
    end

    // Without its own strobe the byte does not move.
    assert_byte_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));
endmodule

// File: rtl/scsi_glue_csr.sv
// Module: top of the SCSI glue register block. Decodes byte accesses,
// holds the two registers, returns read data in the request cycle and
// places the CPU-DMA level at DMA_IRQ_BIT of the interrupt word.
// Assumes a synchronous active-low reset and single-cycle accesses.
module scsi_glue_csr
    import scsi_glue_pkg::*;
#(
    parameter logic [REG_W-1:0] REG1_INIT   = 8'h3C,
    parameter int unsigned      DMA_IRQ_BIT = 26
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_offset,
    input  logic [BYTES_W-1:0] acc_bytes,
    input  logic [REG_W-1:0]   acc_wdata,
    output logic [REG_W-1:0]   acc_rdata,
    output logic               scsi_chip_rst,
    output logic [IRQ_W-1:0]   irq_status
);
    localparam int unsigned NUM_REGS = 2;

    logic             wr_cmd;
    logic             wr_byte;
    logic             rd_ok;
    logic             dma_level;
    logic [REG_W-1:0] regs [NUM_REGS];

    scsi_glue_decode #(.LEGAL_BYTES(1)) u_decode (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_offset (acc_offset),
        .acc_bytes  (acc_bytes),
        .wr_cmd     (wr_cmd),
        .wr_byte    (wr_byte),
        .rd_ok      (rd_ok)
    );

    scsi_glue_cmd_reg u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_cmd),
        .wdata     (acc_wdata),
        .value     (regs[0]),
        .chip_rst  (scsi_chip_rst),
        .dma_level (dma_level)
    );

    scsi_glue_byte_reg #(.INIT(REG1_INIT)) u_byte (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_byte),
        .wdata (acc_wdata),
        .value (regs[1])
    );

    // Purpose: same-cycle read mux; zero when the access is not a legal read.
    always_comb begin
        acc_rdata = rd_ok ? regs[acc_offset] : '0;
    end

    // Purpose: place the DMA level at its bit of the interrupt word.
    always_comb begin
        irq_status              = '0;
        irq_status[DMA_IRQ_BIT] = dma_level;
    end

    // The pulse is only ever caused by a legal reset write at offset 0.
    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scsi_chip_rst |-> ($past(rst_n) && $past(acc_valid && acc_write && !acc_offset
                           && acc_bytes == 3'd1 && acc_wdata[BIT_RESET])));

    // The interrupt bit follows bit 4 of a legal register 0 write.
    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(acc_valid && acc_write && !acc_offset && acc_bytes == 3'd1))
        |-> (irq_status[DMA_IRQ_BIT] == $past(acc_wdata[BIT_CPUDMA])));

    // Only the DMA bit of the interrupt word may ever be set.
    assert_irq_single_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_status) <= 1);

    // Illegal-width reads return zero.
    assert_bad_width_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_bytes != 3'd1) |-> (acc_rdata == '0));
endmodule

// File: tb/scsi_glue_csr_bench.sv
// Directed bench for scsi_glue_csr: one task per scenario, each checking
// its own results. Inputs change on the falling edge; outputs are
// sampled on the falling edge after the accepting rising edge.
module scsi_glue_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_offset = 1'b0;
    logic [2:0]  acc_bytes = 3'd1;
    logic [7:0]  acc_wdata = 8'h00;
    logic [7:0]  acc_rdata;
    logic        scsi_chip_rst;
    logic [31:0] irq_status;

    int n_checks = 0;
    int n_fail   = 0;
    localparam logic [31:0] DMA_BIT = 32'h0400_0000;

    always #2 clk = ~clk;

    scsi_glue_csr u_scsi_glue_csr (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_valid     (acc_valid),
        .acc_write     (acc_write),
        .acc_offset    (acc_offset),
        .acc_bytes     (acc_bytes),
        .acc_wdata     (acc_wdata),
        .acc_rdata     (acc_rdata),
        .scsi_chip_rst (scsi_chip_rst),
        .irq_status    (irq_status)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write on one edge; returns at the falling edge after it.
    task automatic wr(input logic off, input logic [7:0] d, input logic [2:0] nb);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = off;
        acc_bytes = nb; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_bytes = 3'd1;
    endtask

    task automatic rd(input logic off, input logic [2:0] nb, output logic [7:0] q);
        acc_valid = 1'b1; acc_write = 1'b0; acc_offset = off; acc_bytes = nb;
        #1 q = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_bytes = 3'd1;
    endtask

    task automatic t_reset_state;
        logic [7:0] q;
        rd(1'b0, 3'd1, q); check(q == 8'h00, "R1 reg0", q, 8'h00);
        rd(1'b1, 3'd1, q); check(q == 8'h3C, "R1 reg1", q, 8'h3C);
        check(scsi_chip_rst == 1'b0, "R1 pulse", scsi_chip_rst, 0);
        check(irq_status == 32'h0, "R1 irq", irq_status, 0);
    endtask

    task automatic t_byte_reg;
        logic [7:0] q;
        wr(1'b1, 8'hA5, 3'd1);
        check(scsi_chip_rst == 1'b0, "R8 byte write no pulse", scsi_chip_rst, 0);
        check(irq_status == 32'h0, "R8 byte write no irq", irq_status, 0);
        rd(1'b1, 3'd1, q); check(q == 8'hA5, "R2 byte A5", q, 8'hA5);
        wr(1'b1, 8'h5A, 3'd1);
        rd(1'b1, 3'd1, q); check(q == 8'h5A, "R2 byte 5A", q, 8'h5A);
    endtask

    task automatic t_cmd_plain;
        logic [7:0] q;
        wr(1'b0, 8'hBD, 3'd1);
        check(scsi_chip_rst == 1'b0, "R5 no pulse without reset bit", scsi_chip_rst, 0);
        check(irq_status == DMA_BIT, "R6 dma set", irq_status, DMA_BIT);
        rd(1'b0, 3'd1, q); check(q == 8'hBD, "R3 stored BD", q, 8'hBD);
        check(irq_status == DMA_BIT, "R6 dma held", irq_status, DMA_BIT);
        wr(1'b0, 8'h21, 3'd1);
        check(irq_status == 32'h0, "R6 dma cleared", irq_status, 0);
        rd(1'b0, 3'd1, q); check(q == 8'h21, "R3 stored 21", q, 8'h21);
    endtask

    task automatic t_reset_and_dma;
        logic [7:0] q;
        wr(1'b0, 8'hB3, 3'd1);
        check(scsi_chip_rst == 1'b1, "R5 pulse high", scsi_chip_rst, 1);
        check(irq_status == DMA_BIT, "R6 dma with reset", irq_status, DMA_BIT);
        rd(1'b0, 3'd1, q);
        check(scsi_chip_rst == 1'b0, "R5 pulse one clock", scsi_chip_rst, 0);
        check(q == 8'h12, "R4 scrubbed", q, 8'h12);
        rd(1'b1, 3'd1, q); check(q == 8'h5A, "R8 reg1 untouched", q, 8'h5A);
    endtask

    task automatic t_back_to_back;
        logic [7:0] q;
        wr(1'b0, 8'hFF, 3'd1);
        check(scsi_chip_rst == 1'b1, "R5 first pulse", scsi_chip_rst, 1);
        wr(1'b0, 8'h06, 3'd1);
        check(scsi_chip_rst == 1'b1, "R5 second pulse", scsi_chip_rst, 1);
        check(irq_status == 32'h0, "R6 dma off", irq_status, 0);
        @(negedge clk);
        check(scsi_chip_rst == 1'b0, "R5 pulse ends", scsi_chip_rst, 0);
        rd(1'b0, 3'd1, q); check(q == 8'h06, "R4 stored 06", q, 8'h06);
    endtask

    task automatic t_bad_width;
        logic [7:0] q;
        wr(1'b0, 8'h12, 3'd2);
        check(scsi_chip_rst == 1'b0, "R7 no pulse", scsi_chip_rst, 0);
        check(irq_status == 32'h0, "R7 no irq", irq_status, 0);
        wr(1'b1, 8'h77, 3'd4);
        rd(1'b0, 3'd4, q); check(q == 8'h00, "R7 wide read zero", q, 0);
        rd(1'b1, 3'd2, q); check(q == 8'h00, "R7 half read zero", q, 0);
        rd(1'b0, 3'd1, q); check(q == 8'h06, "R7 reg0 kept", q, 8'h06);
        rd(1'b1, 3'd1, q); check(q == 8'h5A, "R7 reg1 kept", q, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_byte_reg();
        t_cmd_plain();
        t_reset_and_dma();
        t_back_to_back();
        t_bad_width();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule